// File: doc/BRIEF.md
# Reloadable Baud Rate Tick Generator

This block derives the timing strobe for an asynchronous serial port from the system clock. A prescaler divides the clock by one of four fixed ratios (1, 4, 12 or 48). Each prescaled step advances a 16-bit up-counter. When the counter passes from all-ones back to zero, the block emits a tick one system clock wide and restarts the count from a programmable 16-bit start value. The tick period is therefore `D * (65536 - R)` system clocks, where `D` is the prescale ratio and `R` is the start value.

Software programs the block through three byte-wide registers, each with its own write strobe: a control byte (enable and prescale select), the upper half of the start value and the lower half of the start value. The serial transmitter and receiver treat the tick as a strobe at twice the bit rate, so two ticks make one bit time. For dependable serial operation the bit rate should stay at or below one sixteenth of the system clock.

Turning the generator on restarts both the counter and the prescaler from a known point. Changing the start value while the generator runs changes only the periods that begin after the next wrap.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the generator is off, the prescale select is divide-by-1 and the start value is 0x0000. `baud_tick` stays low during reset and for as long as the generator is off.
- R2: A write to the control byte takes bit 0 as the enable and bits 2:1 as the prescale select. The encodings are 00 = divide by 1, 01 = divide by 4, 10 = divide by 12 and 11 = divide by 48.
- R3: The upper-byte strobe writes bits 15:8 of the start value and the lower-byte strobe writes bits 7:0. Each write leaves the other byte unchanged.
- R4: A control write that turns the generator on from off loads the counter with the start value and clears the prescaler. The first tick is high in the cycle that follows the clock edge `D * (65536 - R)` edges after the edge that captured the write.
- R5: While the generator is on, ticks repeat every `D * (65536 - R)` system clocks, and each tick is one system clock wide.
- R6: While the generator is off, no tick is produced and the count holds. A write to either start byte while off loads the counter with the updated start value.
- R7: A write to a start byte while the generator is on does not disturb the count in progress. The new value is used from the next wrap onward.
- R8: A control write that keeps the enable set while the generator is already on does not restart the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control byte |
| rld_hi_wr | input | 1 | Write strobe for the upper start-value byte |
| rld_lo_wr | input | 1 | Write strobe for the lower start-value byte |
| wr_data | input | 8 | Data for whichever strobe is active |
| baud_tick | output | 1 | Single-cycle wrap tick (strobe at twice the bit rate) |

## Verification
The assertions check the following on every cycle:
- the counter advances by exactly one on each prescaled step;
- a wrap reloads the start value that was held before the edge, and raises the tick;
- while the generator is off, the count holds still and no tick appears;
- turning the generator on leaves the counter at the start value and the prescaler at zero;
- the prescaler stays within its selected range.

The rest can only be shown by the bench's scenarios:
- the exact period for each prescale ratio;
- the reset defaults, observed through a full 65536-cycle period;
- the byte placement of the start value;
- the point at which a start value written while running first takes effect;
- the absence of a restart when the enable is written again.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic [1:0] {
        PSC_DIV1  = 2'd0,
        PSC_DIV4  = 2'd1,
        PSC_DIV12 = 2'd2,
        PSC_DIV48 = 2'd3
    } psc_sel_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_LSB = 1;
    localparam int NUM_PSC      = 4;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_tick_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 hi_wr,
    input  logic                 lo_wr,
    input  logic [TMR_W/2-1:0]   wdata,
    output logic                 en_o,
    output psc_sel_e             sel_o,
    output logic [TMR_W-1:0]     reload_o,
    output logic                 load_o,
    output logic [TMR_W-1:0]     load_val_o
);
    localparam int BYTE_W = TMR_W / 2;

    typedef struct packed {
        logic              en;
        psc_sel_e          sel;
        logic [TMR_W-1:0]  reload;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_wr) begin
            cfg_d.en  = wdata[CTRL_EN_BIT];
            cfg_d.sel = psc_sel_e'(wdata[CTRL_SEL_LSB +: 2]);
        end
        if (hi_wr) cfg_d.reload[TMR_W-1:BYTE_W] = wdata;
        if (lo_wr) cfg_d.reload[BYTE_W-1:0]     = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{en: 1'b0, sel: PSC_DIV1, reload: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Counter is (re)loaded on an off-to-on transition or on a start write while off.
    assign load_o     = !cfg_q.en && (cfg_d.en || hi_wr || lo_wr);
    assign load_val_o = cfg_d.reload;
    assign en_o       = cfg_q.en;
    assign sel_o      = cfg_q.sel;
    assign reload_o   = cfg_q.reload;

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_tick_pkg::*;
#(
    parameter int unsigned DIV_TABLE [NUM_PSC] = '{1, 4, 12, 48}
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     clear,
    input  psc_sel_e sel,
    output logic     step_o,
    output logic     idle_o
);
    function automatic int unsigned max_div();
        int unsigned m = 1;
        for (int i = 0; i < NUM_PSC; i++) begin
            if (DIV_TABLE[i] > m) m = DIV_TABLE[i];
        end
        return m;
    endfunction

    localparam int PRE_W = (max_div() > 1) ? $clog2(max_div()) : 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t pre_q, pre_d;
    logic [PRE_W-1:0] limit;

    assign limit  = PRE_W'(DIV_TABLE[sel] - 1);
    assign step_o = run && (pre_q.cnt >= limit);
    assign idle_o = (pre_q.cnt == '0);

    always_comb begin
        pre_d = pre_q;
        if (clear) begin
            pre_d.cnt = '0;
        end else if (run) begin
            pre_d.cnt = step_o ? '0 : pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(sel) && !$past(clear)) |-> (pre_q.cnt <= limit)); // R2

endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic [TMR_W-1:0] reload,
    output logic [TMR_W-1:0] count_o,
    output logic             tick_o
);
    localparam logic [TMR_W-1:0] TOP = '1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             tick;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic advance;

    assign advance = run && step;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.tick = 1'b0;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (advance) begin
            if (tmr_q.cnt == TOP) begin
                tmr_d.cnt  = reload;
                tmr_d.tick = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign count_o = tmr_q.cnt;
    assign tick_o  = tmr_q.tick;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && tmr_q.cnt != TOP) |=> (tmr_q.cnt == $past(tmr_q.cnt) + 1'b1) && !tick_o); // R5
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && tmr_q.cnt == TOP) |=> (tmr_q.cnt == $past(reload)) && tick_o); // R7
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(tmr_q.cnt) && !tick_o); // R6

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int          TMR_W = 16,
    parameter int unsigned DIV_TABLE [NUM_PSC] = '{1, 4, 12, 48}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               rld_hi_wr,
    input  logic               rld_lo_wr,
    input  logic [TMR_W/2-1:0] wr_data,
    output logic               baud_tick
);
    logic             en;
    psc_sel_e         sel;
    logic [TMR_W-1:0] reload;
    logic             load;
    logic [TMR_W-1:0] load_val;
    logic             step;
    logic             pre_idle;
    logic [TMR_W-1:0] count;

    baud_cfg_regs #(.TMR_W(TMR_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .hi_wr      (rld_hi_wr),
        .lo_wr      (rld_lo_wr),
        .wdata      (wr_data),
        .en_o       (en),
        .sel_o      (sel),
        .reload_o   (reload),
        .load_o     (load),
        .load_val_o (load_val)
    );

    baud_prescaler #(.DIV_TABLE(DIV_TABLE)) psc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .clear  (load),
        .sel    (sel),
        .step_o (step),
        .idle_o (pre_idle)
    );

    baud_timer #(.TMR_W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en),
        .step     (step),
        .load     (load),
        .load_val (load_val),
        .reload   (reload),
        .count_o  (count),
        .tick_o   (baud_tick)
    );

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (count == reload) && pre_idle); // R4
    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(en)); // R6

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic       rld_hi_wr = 1'b0;
    logic       rld_lo_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   exp_t[$];
    string exp_r[$];
    int   win_ticks = 0;
    bit   done = 0;

    always #4 clk = ~clk;   // 125 MHz

    baud_tick_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .rld_hi_wr (rld_hi_wr),
        .rld_lo_wr (rld_lo_wr),
        .wr_data   (wr_data),
        .baud_tick (baud_tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected tick times and compare with observed ticks.
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_t.size() > 0 && exp_t[0] < cyc) begin
                check(0, {exp_r[0], " missed tick"}, cyc, exp_t[0]);
                void'(exp_t.pop_front());
                void'(exp_r.pop_front());
            end
            if (baud_tick) begin
                win_ticks++;
                if (exp_t.size() == 0) begin
                    check(0, "R5 or R6 unexpected tick", cyc, -1);
                end else begin
                    check(exp_t[0] == cyc, exp_r[0], cyc, exp_t[0]);
                    void'(exp_t.pop_front());
                    void'(exp_r.pop_front());
                end
            end
        end
    end

    function automatic int div_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 12;
            default: return 48;
        endcase
    endfunction

    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        ctrl_wr   = (which == 0);
        rld_hi_wr = (which == 1);
        rld_lo_wr = (which == 2);
        @(negedge clk);
        ctrl_wr = 0; rld_hi_wr = 0; rld_lo_wr = 0;
    endtask

    task automatic set_reload(input logic [15:0] r);
        wr(1, r[15:8]);
        wr(2, r[7:0]);
    endtask

    // Driver: enable, push expected ticks for L cycles, disable, confirm drain.
    task automatic run_case(input string req, input logic [1:0] sel, input int r, input int len);
        int c, p;
        p = div_of(sel) * (65536 - r);
        @(negedge clk);
        c = cyc;
        ctrl_wr = 1; wr_data = {5'b0, sel, 1'b1};
        for (int k = 1; k * p <= len; k++) begin
            exp_t.push_back(c + 1 + k * p);
            exp_r.push_back(req);
        end
        @(negedge clk);
        ctrl_wr = 0;
        while (cyc < c + len) @(negedge clk);
        ctrl_wr = 1; wr_data = 8'h00;
        @(negedge clk);
        ctrl_wr = 0;
        repeat (3) @(negedge clk);
        check(exp_t.size() == 0, {req, " queue drained"}, exp_t.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(baud_tick == 1'b0, "R1 tick low in reset", baud_tick, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(baud_tick == 1'b0, "R1 tick low after reset", baud_tick, 0);

        // R1 defaults: reload 0, divide-by-1 -> 65536-cycle period (R4 first tick)
        run_case("R1", 2'd0, 0, 65536);

        // R5 / R2: each prescale ratio
        set_reload(16'hFFF0);
        run_case("R5 div1", 2'd0, 16'hFFF0, 100);
        set_reload(16'hFFFC);
        run_case("R2 div4", 2'd1, 16'hFFFC, 100);
        set_reload(16'hFFFE);
        run_case("R2 div12", 2'd2, 16'hFFFE, 100);
        set_reload(16'hFFFF);
        run_case("R2 div48", 2'd3, 16'hFFFF, 150);

        // R3: upper byte not all ones
        set_reload(16'hFE00);
        run_case("R3 byte placement", 2'd0, 16'hFE00, 1100);

        // R6: writes while off produce no ticks
        win_ticks = 0;
        set_reload(16'hFFFF);
        wr(0, 8'h06);
        set_reload(16'hFFFE);
        repeat (200) @(negedge clk);
        check(win_ticks == 0, "R6 no ticks while off", win_ticks, 0);

        // R7 and R8: start value change while running, enable rewritten
        set_reload(16'hFFF0);
        begin
            int c;
            @(negedge clk);
            c = cyc;
            ctrl_wr = 1; wr_data = 8'h01;
            exp_t.push_back(c + 17); exp_r.push_back("R7 current period kept");
            for (int k = 1; k <= 5; k++) begin
                exp_t.push_back(c + 17 + 8 * k);
                exp_r.push_back("R7 new period");
            end
            @(negedge clk);
            ctrl_wr = 0;
            while (cyc < c + 5) @(negedge clk);
            rld_lo_wr = 1; wr_data = 8'hF8;
            @(negedge clk);
            rld_lo_wr = 0;
            while (cyc < c + 9) @(negedge clk);
            ctrl_wr = 1; wr_data = 8'h01;   // R8 enable rewritten
            @(negedge clk);
            ctrl_wr = 0;
            while (cyc < c + 56) @(negedge clk);
            ctrl_wr = 1; wr_data = 8'h00;
            @(negedge clk);
            ctrl_wr = 0;
            repeat (3) @(negedge clk);
            check(exp_t.size() == 0, "R8 no restart, queue drained", exp_t.size(), 0);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule